// File: doc/BRIEF.md
# Paired-Page Address Translator

This block turns a 32-bit virtual address into a physical address for an instruction fetch or a data access. A request carries the address, the access size in bytes, a write flag, a fetch flag, the kernel-mode flag, the current address-space identifier and a small-page mode flag. The top two unmapped kernel windows skip the table and map straight through. Every other address is looked up in a small fully associative table. Each table entry maps an even and odd pair of pages that share one tag, and one virtual-address bit picks the half.

The result is either a physical address or a fault code. Faulting responses also carry the data that exception registers need: the faulting virtual address, and the lookup page number split into its two low bits and the remaining upper bits. A write port loads table entries one at a time.

Control is a five-state machine:
- `ST_IDLE` accepts a request and moves to `ST_CLASSIFY`.
- `ST_CLASSIFY` goes straight to `ST_REPLY` when the outcome is already known (unmapped window or misaligned address). Otherwise it moves to `ST_SEARCH`.
- `ST_SEARCH` registers the matching entry and moves to `ST_RESOLVE`.
- `ST_RESOLVE` registers the final result and moves to `ST_REPLY`.
- `ST_REPLY` presents the response for one cycle and returns to `ST_IDLE`.

Top module: `pair_page_xlate`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. A request is taken when `req_valid` and `req_ready` are both high. Each taken request produces exactly one single-cycle `rsp_valid` pulse, with `req_ready` low until that pulse ends and high in the cycle after it.
- R2: Fault codes on `rsp_fault` are: 0 none, 1 address error, 2 refill, 3 invalid, 4 modified. An access is misaligned when ((`req_bytes` − 1) AND `req_vaddr`) is nonzero. A misaligned access to the mapped region or to the cached kernel window returns code 1.
- R3: An address with bits [31:29] = 3'b100 (cached kernel window) bypasses the table with physical = virtual AND 0x1FFF_FFFF. It returns code 1 if `req_kernel` is 0 or the access is misaligned.
- R4: An address with bits [31:29] = 3'b101 (uncached kernel window) uses the same direct mapping and never faults, whatever the mode or alignment.
- R5: In the mapped region, the misalignment outcome takes priority over any table hit or miss.
- R6: The lookup page number is virtual bits [31:11]. Its bits [1:0] are forced to 0 unless `small_pages` is 1.
- R7: An entry matches when the bits at or above position `size` of its page number equal the lookup page number, and either its global bit is set or its identifier equals `req_asid`. When several entries match, the lowest index wins.
- R8: Page shift is 10 + `size`. Virtual bit [shift] picks the even half (bit 0 of the valid and dirty fields, even frame) when 0, and the odd half (bit 1, odd frame) when 1.
- R9: On success the physical address is ({frame, 10'b0} with bits below the shift cleared) OR (virtual address bits below the shift).
- R10: A hit whose selected half is not valid returns code 3.
- R11: A mapped-region access that matches no entry returns code 2.
- R12: A data write (`req_write` = 1, `req_fetch` = 0) to a valid half whose dirty bit is 0 returns code 4. The write flag has no effect on fetches.
- R13: Any fault reports the faulting virtual address on `rsp_badva`. Codes 2, 3 and 4 also report lookup page number bits [1:0] on `rsp_vpn_lo` and the lookup page number shifted right by 2 on `rsp_vpn_hi`.
- R14: After reset every entry holds all zeros (size code 0). A write through the table port replaces the whole entry at `tw_idx` for every request taken afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can accept a request |
| req_vaddr | input | ADDR_W | Virtual address |
| req_bytes | input | BYTES_W | Access size in bytes (1, 2 or 4) |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_kernel | input | 1 | Core is in kernel mode |
| req_asid | input | ASID_W | Current address-space identifier |
| small_pages | input | 1 | Keep lookup page number bits [1:0] |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | IDX_W | Entry index to write |
| tw_vpn | input | VPN_W | Entry page number tag |
| tw_asid | input | ASID_W | Entry identifier |
| tw_global | input | 1 | Entry ignores identifier compare |
| tw_size | input | SZ_W | Page size code, shift = 10 + code |
| tw_pfn_even | input | PFN_W | Even-half frame |
| tw_pfn_odd | input | PFN_W | Odd-half frame |
| tw_valid | input | 2 | Valid bits, bit 0 even, bit 1 odd |
| tw_dirty | input | 2 | Dirty bits, bit 0 even, bit 1 odd |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_fault | output | 3 | Fault code |
| rsp_paddr | output | ADDR_W | Physical address when code is 0 |
| rsp_badva | output | ADDR_W | Faulting virtual address |
| rsp_vpn_lo | output | 2 | Lookup page number bits [1:0] |
| rsp_vpn_hi | output | VPN_W-2 | Lookup page number shifted right by 2 |

## Verification
The bench builds the block with only 4 table entries, while keeping the default address, identifier and size-code widths. Random page numbers drawn from a small pool therefore often land on entries that were overwritten, matched more than once, or shared through the global bit, so the lowest-index rule and the effects of rewriting entries come up constantly. Size codes 0 to 2 are used, so the even/odd select bit and the offset mask take several positions. This covers both the small-page lookup and the ignored low tag bits of larger pages.

// File: rtl/ppx_pkg.sv
package ppx_pkg;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ADDR     = 3'd1,
        FLT_REFILL   = 3'd2,
        FLT_INVALID  = 3'd3,
        FLT_MODIFIED = 3'd4
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_SEARCH,
        ST_RESOLVE,
        ST_REPLY
    } st_e;

    typedef enum logic [1:0] {
        SEG_MAPPED,
        SEG_CACHED,
        SEG_UNCACHED
    } seg_e;

endpackage

// File: rtl/ppx_seg_classify.sv
module ppx_seg_classify
    import ppx_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BYTES_W = 3
) (
    input  logic [ADDR_W-1:0]  va,
    input  logic [BYTES_W-1:0] acc_bytes,
    output seg_e               seg,
    output logic               misaligned,
    output logic [ADDR_W-1:0]  direct_pa
);
    localparam logic [ADDR_W-1:0] DIRECT_MASK = {3'b000, {(ADDR_W-3){1'b1}}};

    logic [BYTES_W-1:0] size_mask;

    always_comb begin
        size_mask  = acc_bytes - BYTES_W'(1);
        misaligned = (size_mask & va[BYTES_W-1:0]) != '0;
        direct_pa  = va & DIRECT_MASK;
        unique case (va[ADDR_W-1 -: 3])
            3'b100:  seg = SEG_CACHED;
            3'b101:  seg = SEG_UNCACHED;
            default: seg = SEG_MAPPED;
        endcase
    end

endmodule

// File: rtl/ppx_entry_table.sv
module ppx_entry_table #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 21,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 22,
    parameter int SZ_W    = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic [PFN_W-1:0]  wr_pfn0,
    input  logic [PFN_W-1:0]  wr_pfn1,
    input  logic [1:0]        wr_valid,
    input  logic [1:0]        wr_dirty,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SZ_W-1:0]   rd_size,
    output logic [PFN_W-1:0]  rd_pfn0,
    output logic [PFN_W-1:0]  rd_pfn1,
    output logic [1:0]        rd_valid,
    output logic [1:0]        rd_dirty
);
    logic [VPN_W-1:0]  vpn_q  [ENTRIES];
    logic [ASID_W-1:0] asid_q [ENTRIES];
    logic              glob_q [ENTRIES];
    logic [SZ_W-1:0]   size_q [ENTRIES];
    logic [PFN_W-1:0]  pfn0_q [ENTRIES];
    logic [PFN_W-1:0]  pfn1_q [ENTRIES];
    logic [1:0]        vld_q  [ENTRIES];
    logic [1:0]        drt_q  [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i]  <= '0;
                asid_q[i] <= '0;
                glob_q[i] <= 1'b0;
                size_q[i] <= '0;
                pfn0_q[i] <= '0;
                pfn1_q[i] <= '0;
                vld_q[i]  <= '0;
                drt_q[i]  <= '0;
            end
        end else if (wr_en) begin
            vpn_q[wr_idx]  <= wr_vpn;
            asid_q[wr_idx] <= wr_asid;
            glob_q[wr_idx] <= wr_global;
            size_q[wr_idx] <= wr_size;
            pfn0_q[wr_idx] <= wr_pfn0;
            pfn1_q[wr_idx] <= wr_pfn1;
            vld_q[wr_idx]  <= wr_valid;
            drt_q[wr_idx]  <= wr_dirty;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] care;
        assign care     = ~((VPN_W'(1) << size_q[g]) - VPN_W'(1));
        assign match[g] = (((vpn_q[g] ^ lk_vpn) & care) == '0)
                          && (glob_q[g] || (asid_q[g] == lk_asid));
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
            end
        end
    end

    assign rd_size  = size_q[rd_idx];
    assign rd_pfn0  = pfn0_q[rd_idx];
    assign rd_pfn1  = pfn1_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
    assign rd_dirty = drt_q[rd_idx];

endmodule

// File: rtl/ppx_page_resolve.sv
module ppx_page_resolve
    import ppx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 10,
    parameter int SZ_W      = 4,
    localparam int PFN_W    = ADDR_W - MIN_SHIFT,
    localparam int SH_W     = $clog2(ADDR_W) + 1
) (
    input  logic [ADDR_W-1:0] va,
    input  logic [SZ_W-1:0]   size,
    input  logic [PFN_W-1:0]  pfn0,
    input  logic [PFN_W-1:0]  pfn1,
    input  logic [1:0]        valid,
    input  logic [1:0]        dirty,
    input  logic              data_write,
    output flt_e              fault,
    output logic [ADDR_W-1:0] pa
);
    logic [SH_W-1:0]   shift;
    logic [ADDR_W-1:0] shifted_va;
    logic [ADDR_W-1:0] off_mask;
    logic [ADDR_W-1:0] frame_base;
    logic              odd;

    always_comb begin
        shift      = SH_W'(MIN_SHIFT) + SH_W'(size);
        shifted_va = va >> shift;
        odd        = shifted_va[0];
        off_mask   = (ADDR_W'(1) << shift) - ADDR_W'(1);
        frame_base = odd ? {pfn1, {MIN_SHIFT{1'b0}}} : {pfn0, {MIN_SHIFT{1'b0}}};
        pa         = (frame_base & ~off_mask) | (va & off_mask);
        if (!valid[odd]) begin
            fault = FLT_INVALID;
        end else if (data_write && !dirty[odd]) begin
            fault = FLT_MODIFIED;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/pair_page_xlate.sv
module pair_page_xlate
    import ppx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 10,
    parameter int ENTRIES   = 16,
    parameter int ASID_W    = 8,
    parameter int SZ_W      = 4,
    parameter int BYTES_W   = 3,
    localparam int VPN_LSB  = MIN_SHIFT + 1,
    localparam int VPN_W    = ADDR_W - VPN_LSB,
    localparam int PFN_W    = ADDR_W - MIN_SHIFT,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic               req_write,
    input  logic               req_fetch,
    input  logic               req_kernel,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic               small_pages,
    input  logic               tw_en,
    input  logic [IDX_W-1:0]   tw_idx,
    input  logic [VPN_W-1:0]   tw_vpn,
    input  logic [ASID_W-1:0]  tw_asid,
    input  logic               tw_global,
    input  logic [SZ_W-1:0]    tw_size,
    input  logic [PFN_W-1:0]   tw_pfn_even,
    input  logic [PFN_W-1:0]   tw_pfn_odd,
    input  logic [1:0]         tw_valid,
    input  logic [1:0]         tw_dirty,
    output logic               rsp_valid,
    output logic [2:0]         rsp_fault,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic [ADDR_W-1:0]  rsp_badva,
    output logic [1:0]         rsp_vpn_lo,
    output logic [VPN_W-3:0]   rsp_vpn_hi
);
    st_e state_q, state_d;

    logic [ADDR_W-1:0]  va_q;
    logic [BYTES_W-1:0] bytes_q;
    logic               dwrite_q;
    logic               kern_q;
    logic [ASID_W-1:0]  asid_q;
    logic               sp_q;
    logic               hit_q;
    logic [IDX_W-1:0]   idx_q;
    flt_e               res_fault_q;
    logic [ADDR_W-1:0]  res_pa_q;

    seg_e              seg;
    logic              misaligned;
    logic [ADDR_W-1:0] direct_pa;
    logic [VPN_W-1:0]  lk_vpn;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [SZ_W-1:0]   ent_size;
    logic [PFN_W-1:0]  ent_pfn0;
    logic [PFN_W-1:0]  ent_pfn1;
    logic [1:0]        ent_valid;
    logic [1:0]        ent_dirty;
    flt_e              page_fault;
    logic [ADDR_W-1:0] page_pa;
    logic              early_done;
    flt_e              early_fault;

    ppx_seg_classify #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) u_classify (
        .va         (va_q),
        .acc_bytes  (bytes_q),
        .seg        (seg),
        .misaligned (misaligned),
        .direct_pa  (direct_pa)
    );

    always_comb begin
        lk_vpn = va_q[ADDR_W-1:VPN_LSB];
        if (!sp_q) begin
            lk_vpn[1:0] = 2'b00;
        end
    end

    ppx_entry_table #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .PFN_W(PFN_W), .SZ_W(SZ_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tw_en),
        .wr_idx    (tw_idx),
        .wr_vpn    (tw_vpn),
        .wr_asid   (tw_asid),
        .wr_global (tw_global),
        .wr_size   (tw_size),
        .wr_pfn0   (tw_pfn_even),
        .wr_pfn1   (tw_pfn_odd),
        .wr_valid  (tw_valid),
        .wr_dirty  (tw_dirty),
        .lk_vpn    (lk_vpn),
        .lk_asid   (asid_q),
        .lk_hit    (lk_hit),
        .lk_idx    (lk_idx),
        .rd_idx    (idx_q),
        .rd_size   (ent_size),
        .rd_pfn0   (ent_pfn0),
        .rd_pfn1   (ent_pfn1),
        .rd_valid  (ent_valid),
        .rd_dirty  (ent_dirty)
    );

    ppx_page_resolve #(.ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT), .SZ_W(SZ_W)) u_resolve (
        .va         (va_q),
        .size       (ent_size),
        .pfn0       (ent_pfn0),
        .pfn1       (ent_pfn1),
        .valid      (ent_valid),
        .dirty      (ent_dirty),
        .data_write (dwrite_q),
        .fault      (page_fault),
        .pa         (page_pa)
    );

    // Outcome known already in ST_CLASSIFY: bypass windows and misaligned mapped accesses.
    always_comb begin
        early_done  = 1'b1;
        early_fault = FLT_NONE;
        unique case (seg)
            SEG_CACHED:   early_fault = (!kern_q || misaligned) ? FLT_ADDR : FLT_NONE;
            SEG_UNCACHED: early_fault = FLT_NONE;
            SEG_MAPPED: begin
                early_done  = misaligned;
                early_fault = FLT_ADDR;
            end
            default:      early_fault = FLT_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_CLASSIFY;
            ST_CLASSIFY: state_d = early_done ? ST_REPLY : ST_SEARCH;
            ST_SEARCH:   state_d = ST_RESOLVE;
            ST_RESOLVE:  state_d = ST_REPLY;
            ST_REPLY:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q        <= '0;
            bytes_q     <= '0;
            dwrite_q    <= 1'b0;
            kern_q      <= 1'b0;
            asid_q      <= '0;
            sp_q        <= 1'b0;
            hit_q       <= 1'b0;
            idx_q       <= '0;
            res_fault_q <= FLT_NONE;
            res_pa_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q     <= req_vaddr;
                        bytes_q  <= req_bytes;
                        dwrite_q <= req_write && !req_fetch;
                        kern_q   <= req_kernel;
                        asid_q   <= req_asid;
                        sp_q     <= small_pages;
                    end
                end
                ST_CLASSIFY: begin
                    if (early_done) begin
                        res_fault_q <= early_fault;
                        res_pa_q    <= direct_pa;
                    end
                end
                ST_SEARCH: begin
                    hit_q <= lk_hit;
                    idx_q <= lk_idx;
                end
                ST_RESOLVE: begin
                    res_fault_q <= hit_q ? page_fault : FLT_REFILL;
                    res_pa_q    <= page_pa;
                end
                ST_REPLY: begin
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_valid  = (state_q == ST_REPLY);
        rsp_fault  = res_fault_q;
        rsp_paddr  = res_pa_q;
        rsp_badva  = va_q;
        rsp_vpn_lo = lk_vpn[1:0];
        rsp_vpn_hi = lk_vpn[VPN_W-1:2];
    end

endmodule

// File: rtl/ppx_checker.sv
module ppx_checker #(
    parameter int ADDR_W  = 32,
    parameter int BYTES_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_vaddr,
    input logic [BYTES_W-1:0] req_bytes,
    input logic               req_kernel,
    input logic               rsp_valid,
    input logic [2:0]         rsp_fault,
    input logic [ADDR_W-1:0]  rsp_paddr,
    input logic [ADDR_W-1:0]  rsp_badva
);
    localparam logic [ADDR_W-1:0] LOW_MASK = {3'b000, {(ADDR_W-3){1'b1}}};

    logic [ADDR_W-1:0]  cap_va;
    logic [BYTES_W-1:0] cap_bytes;
    logic               cap_kern;
    logic               cap_mis;
    logic [2:0]         cap_seg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_va    <= '0;
            cap_bytes <= BYTES_W'(1);
            cap_kern  <= 1'b1;
        end else if (req_valid && req_ready) begin
            cap_va    <= req_vaddr;
            cap_bytes <= req_bytes;
            cap_kern  <= req_kernel;
        end
    end

    assign cap_mis = ((cap_bytes - BYTES_W'(1)) & cap_va[BYTES_W-1:0]) != '0;
    assign cap_seg = cap_va[ADDR_W-1 -: 3];

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_READY_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready); // R1
    AST_BUSY_DURING_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R1
    AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cap_seg != 3'b101 && cap_mis) |-> rsp_fault == 3'd1); // R2
    AST_CACHED_USER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cap_seg == 3'b100 && !cap_kern) |-> rsp_fault == 3'd1); // R3
    AST_UNCACHED_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cap_seg == 3'b101)
        |-> (rsp_fault == 3'd0 && rsp_paddr == (cap_va & LOW_MASK))); // R4
    AST_BADVA_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> rsp_badva == cap_va); // R13

endmodule

bind pair_page_xlate ppx_checker #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .req_bytes  (req_bytes),
    .req_kernel (req_kernel),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .rsp_badva  (rsp_badva)
);

// File: tb/pair_page_xlate_bench.sv
module pair_page_xlate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [2:0]  req_bytes = 3'd4;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic        req_kernel = 1'b1;
    logic [7:0]  req_asid = '0;
    logic        small_pages = 1'b0;
    logic        tw_en = 1'b0;
    logic [1:0]  tw_idx = '0;
    logic [20:0] tw_vpn = '0;
    logic [7:0]  tw_asid = '0;
    logic        tw_global = 1'b0;
    logic [3:0]  tw_size = '0;
    logic [21:0] tw_pfn_even = '0;
    logic [21:0] tw_pfn_odd = '0;
    logic [1:0]  tw_valid = '0;
    logic [1:0]  tw_dirty = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_badva;
    logic [1:0]  rsp_vpn_lo;
    logic [18:0] rsp_vpn_hi;

    int total = 0;
    int bad = 0;

    logic [20:0] m_vpn  [NE];
    logic [7:0]  m_asid [NE];
    logic        m_glob [NE];
    logic [3:0]  m_size [NE];
    logic [21:0] m_pfn0 [NE];
    logic [21:0] m_pfn1 [NE];
    logic [1:0]  m_vld  [NE];
    logic [1:0]  m_drt  [NE];

    pair_page_xlate #(.ENTRIES(NE)) u_pair_page_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_bytes(req_bytes), .req_write(req_write),
        .req_fetch(req_fetch), .req_kernel(req_kernel), .req_asid(req_asid),
        .small_pages(small_pages), .tw_en(tw_en), .tw_idx(tw_idx), .tw_vpn(tw_vpn),
        .tw_asid(tw_asid), .tw_global(tw_global), .tw_size(tw_size),
        .tw_pfn_even(tw_pfn_even), .tw_pfn_odd(tw_pfn_odd), .tw_valid(tw_valid),
        .tw_dirty(tw_dirty), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_badva(rsp_badva), .rsp_vpn_lo(rsp_vpn_lo),
        .rsp_vpn_hi(rsp_vpn_hi)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic write_entry(input int idx, input logic [20:0] vpn, input logic [7:0] asid,
                               input logic glob, input logic [3:0] size,
                               input logic [21:0] p0, input logic [21:0] p1,
                               input logic [1:0] v, input logic [1:0] d);
        @(negedge clk);
        tw_en = 1'b1; tw_idx = 2'(idx); tw_vpn = vpn; tw_asid = asid; tw_global = glob;
        tw_size = size; tw_pfn_even = p0; tw_pfn_odd = p1; tw_valid = v; tw_dirty = d;
        @(negedge clk);
        tw_en = 1'b0;
        m_vpn[idx] = vpn; m_asid[idx] = asid; m_glob[idx] = glob; m_size[idx] = size;
        m_pfn0[idx] = p0; m_pfn1[idx] = p1; m_vld[idx] = v; m_drt[idx] = d;
    endtask

    // Expected outcome built from the requirements.
    task automatic predict(input logic [31:0] va, input logic [2:0] nb, input logic wr,
                           input logic fe, input logic ke, input logic [7:0] as, input logic sp,
                           output logic [2:0] f, output logic [31:0] pa,
                           output logic [1:0] lo, output logic [18:0] hi, output string rt);
        logic [20:0] vpn;
        logic [20:0] care;
        logic        mis;
        logic        odd;
        logic [31:0] om;
        logic [21:0] pfn;
        int          hitn;
        int          sh;
        mis = ((nb - 3'd1) & va[2:0]) != 3'd0;
        vpn = va[31:11];
        if (!sp) vpn[1:0] = 2'b00;
        lo = vpn[1:0];
        hi = vpn[20:2];
        pa = '0;
        f = 3'd0;
        rt = "R9";
        if (va[31:29] == 3'b100) begin
            pa = va & 32'h1FFF_FFFF;
            f = (!ke || mis) ? 3'd1 : 3'd0;
            rt = "R3";
        end else if (va[31:29] == 3'b101) begin
            pa = va & 32'h1FFF_FFFF;
            rt = "R4";
        end else if (mis) begin
            f = 3'd1;
            rt = "R5";
        end else begin
            hitn = -1;
            for (int i = NE - 1; i >= 0; i--) begin
                care = ~((21'd1 << m_size[i]) - 21'd1);
                if ((((m_vpn[i] ^ vpn) & care) == 21'd0) && (m_glob[i] || m_asid[i] == as))
                    hitn = i;
            end
            if (hitn < 0) begin
                f = 3'd2;
                rt = "R11";
            end else begin
                sh = 10 + int'(m_size[hitn]);
                odd = va[sh];
                om = (32'd1 << sh) - 32'd1;
                pfn = odd ? m_pfn1[hitn] : m_pfn0[hitn];
                pa = ({pfn, 10'b0} & ~om) | (va & om);
                if (!m_vld[hitn][odd]) begin
                    f = 3'd3;
                    rt = "R10";
                end else if (wr && !fe && !m_drt[hitn][odd]) begin
                    f = 3'd4;
                    rt = "R12";
                end
            end
        end
    endtask

    task automatic xlate(input logic [31:0] va, input logic [2:0] nb, input logic wr,
                         input logic fe, input logic ke, input logic [7:0] as,
                         input logic sp, input string tag);
        logic [2:0]  ef;
        logic [31:0] epa;
        logic [1:0]  elo;
        logic [18:0] ehi;
        string       rt;
        string       t;
        int          n;
        predict(va, nb, wr, fe, ke, as, sp, ef, epa, elo, ehi, rt);
        t = {tag, "/", rt};
        @(negedge clk);
        req_vaddr = va; req_bytes = nb; req_write = wr; req_fetch = fe;
        req_kernel = ke; req_asid = as; small_pages = sp; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(rsp_valid, "R1", "response seen", 32'(rsp_valid), 32'd1);
        check(rsp_fault == ef, t, "fault code", 32'(rsp_fault), 32'(ef));
        if (ef == 3'd0) begin
            check(rsp_paddr == epa, t, "paddr", rsp_paddr, epa);
        end else begin
            check(rsp_badva == va, {"R13 ", t}, "badva", rsp_badva, va);
            if (ef >= 3'd2) begin
                check(rsp_vpn_lo == elo, {"R13 ", t}, "vpn_lo", 32'(rsp_vpn_lo), 32'(elo));
                check(rsp_vpn_hi == ehi, {"R13 ", t}, "vpn_hi", 32'(rsp_vpn_hi), 32'(ehi));
            end
        end
        @(negedge clk);
        check(!rsp_valid && req_ready, "R1", "pulse end and ready",
              {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [20:0] pool [6];
        int          seed;
        logic [2:0]  sz;
        logic [31:0] va;
        int          pick;
        seed = int'($urandom(32'h5EED_0007));
        pool[0] = 21'h00100; pool[1] = 21'h00101; pool[2] = 21'h00103;
        pool[3] = 21'h00200; pool[4] = 21'h003C4; pool[5] = 21'h07FFF;
        for (int i = 0; i < NE; i++) begin
            m_vpn[i] = '0; m_asid[i] = '0; m_glob[i] = 1'b0; m_size[i] = '0;
            m_pfn0[i] = '0; m_pfn1[i] = '0; m_vld[i] = '0; m_drt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1", "no response after reset", 32'(rsp_valid), 32'd0);

        // R14 zeroed entries match page 0 / id 0 and report invalid (R10)
        xlate(32'h0000_0400, 3'd4, 1'b0, 1'b0, 1'b1, 8'd0, 1'b0, "R14 reset entries");
        // R3 cached window
        xlate(32'h8000_1000, 3'd4, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, "R3 user");
        xlate(32'h8123_4564, 3'd4, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, "R3 kernel");
        xlate(32'h8000_0002, 3'd4, 1'b1, 1'b0, 1'b1, 8'd1, 1'b0, "R2 cached misaligned");
        // R4 uncached window never faults
        xlate(32'hA000_0003, 3'd2, 1'b1, 1'b0, 1'b0, 8'd1, 1'b0, "R4 user misaligned");

        write_entry(1, 21'h00100, 8'd1, 1'b0, 4'd2, 22'h000400, 22'h000800, 2'b11, 2'b01);
        xlate(32'h0008_0123, 3'd4, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, "R8 even R9");
        xlate(32'h0008_1123, 3'd4, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, "R8 odd R9");
        xlate(32'h0008_1124, 3'd4, 1'b1, 1'b0, 1'b1, 8'd1, 1'b0, "R12 clean write");
        xlate(32'h0008_1124, 3'd4, 1'b1, 1'b1, 1'b1, 8'd1, 1'b0, "R12 fetch ignores write");
        xlate(32'h0008_0124, 3'd4, 1'b1, 1'b0, 1'b1, 8'd1, 1'b0, "R12 dirty write");
        xlate(32'h0008_0124, 3'd4, 1'b0, 1'b0, 1'b1, 8'd2, 1'b0, "R11 R7 id mismatch");
        write_entry(2, 21'h00200, 8'd5, 1'b1, 4'd2, 22'h001234, 22'h002345, 2'b11, 2'b11);
        xlate(32'h0010_0ABC, 3'd4, 1'b0, 1'b0, 1'b1, 8'd2, 1'b0, "R7 global");
        xlate(32'h0008_0121, 3'd2, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, "R5 misaligned hit");
        write_entry(3, 21'h00100, 8'd1, 1'b0, 4'd2, 22'h003000, 22'h003100, 2'b11, 2'b11);
        xlate(32'h0008_0010, 3'd1, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, "R7 lowest index");
        write_entry(1, 21'h00100, 8'd1, 1'b0, 4'd2, 22'h000400, 22'h000800, 2'b00, 2'b00);
        xlate(32'h0008_0010, 3'd1, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, "R14 overwrite");
        write_entry(0, 21'h00301, 8'd1, 1'b0, 4'd0, 22'h000055, 22'h000066, 2'b11, 2'b11);
        xlate(32'h0018_0C00, 3'd4, 1'b0, 1'b0, 1'b1, 8'd1, 1'b1, "R6 small pages");
        xlate(32'h0018_0C00, 3'd4, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, "R6 normal pages");

        // Random phase
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 5) == 0) begin
                write_entry(int'($urandom_range(0, NE - 1)), pool[$urandom_range(0, 5)],
                            8'($urandom_range(1, 2)), 1'($urandom_range(0, 3) == 0),
                            4'($urandom_range(0, 2)), 22'($urandom), 22'($urandom),
                            2'($urandom), 2'($urandom));
            end
            pick = int'($urandom_range(0, 9));
            if (pick == 0) va = {3'b100, 29'($urandom)};
            else if (pick == 1) va = {3'b101, 29'($urandom)};
            else va = {pool[$urandom_range(0, 5)], 11'($urandom)};
            pick = int'($urandom_range(0, 2));
            sz = (pick == 0) ? 3'd1 : ((pick == 1) ? 3'd2 : 3'd4);
            xlate(va, sz, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0),
                  8'($urandom_range(1, 2)), 1'($urandom), "random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule